// File: doc/BRIEF.md
# Slew Parameter Best-Fit Search Engine

This block turns a requested full-scale slew time, given in microseconds, into the pair of table indices that set the output ramp of a precision output stage. One index picks the update clock rate and the other picks the code step size. The engine tries every update clock rate in turn. For each rate it works out the step size that would ideally give the requested time and rounds that step up to a step-table entry. It then works out the slew time that this pair really produces and keeps the pair whose time lies closest to the request.

All division is done by one shared shift-subtract divider, which produces one quotient bit per cycle. A full search therefore takes a few thousand cycles. The caller presents the request with a single-cycle start strobe. The engine answers with a single-cycle done pulse. With the pulse come the two indices and a packed 16-bit configuration word. All result outputs hold their values until the next done pulse.

Top module: `slew_fit_engine`

## Requirements
- R1: After reset, done and req_err are 0, and clk_sel, step_sel and cfg_word are all 0.
- R2: For update clock index i, the ideal step is (65535000000 / rate[i]) / slew_us, using truncating integer division in that order. The rate table for indices 0..15 is 240000, 200000, 150000, 128000, 64000, 32000, 16000, 8000, 4000, 2000, 1000, 512, 256, 128, 64, 16. The chosen step index is the lowest index whose entry in the step table (4, 12, 64, 120, 256, 500, 1820, 2048 for indices 0..7) is greater than or equal to the ideal step. If no entry is large enough, the step index is 7.
- R3: The achieved time is (65535000000 / step[j]) / rate[i], using truncating division. Its error is the absolute difference from slew_us. The reported pair is the one with the smallest error over all 16 clock indices. On equal errors the lower clock index is kept.
- R4: cfg_word carries the step index in bits 15:13, the clock index in bits 12:9 and a 1 in bit 8. Bits 7:0 are 0.
- R5: A start with slew_us equal to 0 starts no search. done and req_err are 1 on the cycle after the start, with clk_sel, step_sel and cfg_word all 0. The next successful search returns req_err to 0.
- R6: done is high for exactly one cycle per accepted request. clk_sel, step_sel, cfg_word and req_err stay unchanged between done pulses.
- R7: A start that arrives while a search is running has no effect on the result of that search.
- R8: A start presented in the cycle in which done is high is accepted as a new request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Single-cycle request strobe |
| slew_us | input | 32 | Requested full-scale slew time in microseconds |
| done | output | 1 | One-cycle completion pulse |
| req_err | output | 1 | Set when the request was a zero slew time |
| clk_sel | output | 4 | Chosen update clock index |
| step_sel | output | 3 | Chosen step size index |
| cfg_word | output | 16 | Packed configuration word |

## Verification
Two functions can land in the same cycle: the done pulse that ends one search and the start strobe that opens the next. Both also share a cycle with the busy window, in which a second start must be dropped. The bench provokes the first case by raising start in the cycle it sees done. It then checks that a second done arrives carrying the result modelled for the new request. It provokes the second case by pulsing a different slew time in the middle of a running search. It then checks that the result matches the first request only.

// File: rtl/slew_fit_pkg.sv
package slew_fit_pkg;

  localparam int SLEW_W  = 32;
  localparam int ACC_W   = 64;
  localparam int CLK_N   = 16;
  localparam int STEP_N  = 8;
  localparam int CLK_IW  = $clog2(CLK_N);
  localparam int STEP_IW = $clog2(STEP_N);
  localparam int CFG_W   = 16;
  localparam logic [ACC_W-1:0] NUMER = 64'd65535000000;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LAUNCH,
    ST_WAIT,
    ST_DONE
  } fit_state_t;

  typedef struct packed {
    logic [STEP_IW-1:0] step;
    logic [CLK_IW-1:0]  rate;
    logic               en;
    logic [7:0]         pad;
  } slew_cfg_t;

  function automatic logic [SLEW_W-1:0] clk_rate(input logic [CLK_IW-1:0] i);
    logic [SLEW_W-1:0] r;
    case (i)
      4'd0:    r = 32'd240000;
      4'd1:    r = 32'd200000;
      4'd2:    r = 32'd150000;
      4'd3:    r = 32'd128000;
      4'd4:    r = 32'd64000;
      4'd5:    r = 32'd32000;
      4'd6:    r = 32'd16000;
      4'd7:    r = 32'd8000;
      4'd8:    r = 32'd4000;
      4'd9:    r = 32'd2000;
      4'd10:   r = 32'd1000;
      4'd11:   r = 32'd512;
      4'd12:   r = 32'd256;
      4'd13:   r = 32'd128;
      4'd14:   r = 32'd64;
      default: r = 32'd16;
    endcase
    return r;
  endfunction

  function automatic logic [SLEW_W-1:0] step_size(input logic [STEP_IW-1:0] j);
    logic [SLEW_W-1:0] s;
    case (j)
      3'd0:    s = 32'd4;
      3'd1:    s = 32'd12;
      3'd2:    s = 32'd64;
      3'd3:    s = 32'd120;
      3'd4:    s = 32'd256;
      3'd5:    s = 32'd500;
      3'd6:    s = 32'd1820;
      default: s = 32'd2048;
    endcase
    return s;
  endfunction

  // Round an ideal step up to the lowest table entry that covers it.
  function automatic logic [STEP_IW-1:0] snap_step(input logic [ACC_W-1:0] ideal);
    logic [STEP_IW-1:0] sel;
    sel = STEP_IW'(STEP_N - 1);
    for (int j = STEP_N - 1; j >= 0; j--) begin
      if (ideal <= ACC_W'(step_size(STEP_IW'(j)))) sel = STEP_IW'(j);
    end
    return sel;
  endfunction

  function automatic logic [ACC_W-1:0] abs_diff(input logic [ACC_W-1:0] a,
                                                input logic [ACC_W-1:0] b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

  function automatic logic [CFG_W-1:0] pack_cfg(input logic [CLK_IW-1:0] rate,
                                                input logic [STEP_IW-1:0] step);
    slew_cfg_t c;
    c.step = step;
    c.rate = rate;
    c.en   = 1'b1;
    c.pad  = 8'h00;
    return c;
  endfunction

endpackage

// File: rtl/slew_fit_div.sv
module slew_fit_div #(
  parameter int NUM_W = 64,
  parameter int DEN_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             fin,
  output logic [NUM_W-1:0] quo
);

  localparam int CNT_W = $clog2(NUM_W + 1);
  localparam int PW    = NUM_W + DEN_W;

  logic [DEN_W:0]   rem;
  logic [DEN_W:0]   rem_sh;
  logic [DEN_W:0]   rem_nx;
  logic             take_bit;
  logic [DEN_W-1:0] den_q;
  logic [NUM_W-1:0] num_q;
  logic [CNT_W-1:0] cnt;
  logic             run;

  always_comb begin
    rem_sh   = {rem[DEN_W-1:0], quo[NUM_W-1]};
    take_bit = (rem_sh >= {1'b0, den_q});
    rem_nx   = take_bit ? (rem_sh - {1'b0, den_q}) : rem_sh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem   <= '0;
      quo   <= '0;
      den_q <= '0;
      num_q <= '0;
      cnt   <= '0;
      run   <= 1'b0;
      fin   <= 1'b0;
    end else if (go && !run) begin
      rem   <= '0;
      quo   <= num;
      num_q <= num;
      den_q <= den;
      cnt   <= CNT_W'(NUM_W);
      run   <= 1'b1;
      fin   <= 1'b0;
    end else if (run) begin
      rem <= rem_nx;
      quo <= {quo[NUM_W-2:0], take_bit};
      cnt <= cnt - 1'b1;
      if (cnt == CNT_W'(1)) begin
        run <= 1'b0;
        fin <= 1'b1;
      end
    end else begin
      fin <= 1'b0;
    end
  end

  // A finished quotient is the truncated ratio of the latched operands.
  logic [PW-1:0] prod_lo;
  logic [PW-1:0] prod_hi;
  assign prod_lo = PW'(quo) * PW'(den_q);
  assign prod_hi = prod_lo + PW'(den_q);

  assert_div_exact_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> (prod_lo <= PW'(num_q)) && (prod_hi > PW'(num_q)));

  assert_div_fin_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !fin);

endmodule

// File: rtl/slew_fit_keep.sv
module slew_fit_keep #(
  parameter int ERR_W = 64,
  parameter int CI_W  = 4,
  parameter int SI_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             offer,
  input  logic [ERR_W-1:0] cand_err,
  input  logic [CI_W-1:0]  cand_clk,
  input  logic [SI_W-1:0]  cand_step,
  output logic [ERR_W-1:0] best_err,
  output logic [CI_W-1:0]  best_clk,
  output logic [SI_W-1:0]  best_step
);

  localparam logic [ERR_W-1:0] ERR_INIT = {1'b0, {(ERR_W-1){1'b1}}};

  logic took;
  assign took = offer && (cand_err < best_err);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_err  <= ERR_INIT;
      best_clk  <= '0;
      best_step <= '0;
    end else if (clear) begin
      best_err  <= ERR_INIT;
      best_clk  <= '0;
      best_step <= '0;
    end else if (took) begin
      best_err  <= cand_err;
      best_clk  <= cand_clk;
      best_step <= cand_step;
    end
  end

  // The retained error never grows during a search.
  assert_keep_monotone_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> best_err <= $past(best_err));

  // An equal error must not displace the earlier candidate.
  assert_keep_tie_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && offer && (cand_err == best_err)) |=> $stable(best_clk));

endmodule

// File: rtl/slew_fit_engine.sv
module slew_fit_engine
  import slew_fit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SLEW_W-1:0] slew_us,
  output logic              done,
  output logic              req_err,
  output logic [CLK_IW-1:0] clk_sel,
  output logic [STEP_IW-1:0] step_sel,
  output logic [CFG_W-1:0]  cfg_word
);

  fit_state_t         state;
  logic [SLEW_W-1:0]  slew_q;
  logic [CLK_IW-1:0]  ci;
  logic [1:0]         phase;
  logic [ACC_W-1:0]   q_hold;
  logic [ACC_W-1:0]   ideal_q;
  logic [STEP_IW-1:0] step_q;

  logic               div_go;
  logic [ACC_W-1:0]   div_num;
  logic [SLEW_W-1:0]  div_den;
  logic               div_fin;
  logic [ACC_W-1:0]   div_quo;

  logic               keep_clear;
  logic               keep_offer;
  logic [ACC_W-1:0]   cand_err;
  logic [ACC_W-1:0]   best_err;
  logic [CLK_IW-1:0]  best_clk;
  logic [STEP_IW-1:0] best_step;

  // Named events for the assertions.
  logic accept_start;
  logic zero_req;
  logic drop_start;
  logic last_clk;

  assign accept_start = start && (state == ST_IDLE);
  assign zero_req     = accept_start && (slew_us == '0);
  assign drop_start   = start && (state != ST_IDLE);
  assign last_clk     = (ci == CLK_IW'(CLK_N - 1));

  // Operand selection per division phase.
  always_comb begin
    unique case (phase)
      2'd0: begin
        div_num = NUMER;
        div_den = clk_rate(ci);
      end
      2'd1: begin
        div_num = q_hold;
        div_den = slew_q;
      end
      2'd2: begin
        div_num = NUMER;
        div_den = step_size(step_q);
      end
      default: begin
        div_num = q_hold;
        div_den = clk_rate(ci);
      end
    endcase
  end

  assign div_go     = (state == ST_LAUNCH);
  assign keep_clear = accept_start;
  assign keep_offer = (state == ST_WAIT) && div_fin && (phase == 2'd3);
  assign cand_err   = abs_diff(ACC_W'(slew_q), div_quo);

  slew_fit_div #(
    .NUM_W(ACC_W),
    .DEN_W(SLEW_W)
  ) div_u (
    .clk  (clk),
    .rst_n(rst_n),
    .go   (div_go),
    .num  (div_num),
    .den  (div_den),
    .fin  (div_fin),
    .quo  (div_quo)
  );

  slew_fit_keep #(
    .ERR_W(ACC_W),
    .CI_W (CLK_IW),
    .SI_W (STEP_IW)
  ) keep_u (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (keep_clear),
    .offer    (keep_offer),
    .cand_err (cand_err),
    .cand_clk (ci),
    .cand_step(step_q),
    .best_err (best_err),
    .best_clk (best_clk),
    .best_step(best_step)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      slew_q   <= '0;
      ci       <= '0;
      phase    <= '0;
      q_hold   <= '0;
      ideal_q  <= '0;
      step_q   <= '0;
      done     <= 1'b0;
      req_err  <= 1'b0;
      clk_sel  <= '0;
      step_sel <= '0;
      cfg_word <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (zero_req) begin
            done     <= 1'b1;
            req_err  <= 1'b1;
            clk_sel  <= '0;
            step_sel <= '0;
            cfg_word <= '0;
          end else if (accept_start) begin
            slew_q <= slew_us;
            ci     <= '0;
            phase  <= 2'd0;
            state  <= ST_LAUNCH;
          end
        end
        ST_LAUNCH: state <= ST_WAIT;
        ST_WAIT: begin
          if (div_fin) begin
            unique case (phase)
              2'd0: begin
                q_hold <= div_quo;
                phase  <= 2'd1;
                state  <= ST_LAUNCH;
              end
              2'd1: begin
                ideal_q <= div_quo;
                step_q  <= snap_step(div_quo);
                phase   <= 2'd2;
                state   <= ST_LAUNCH;
              end
              2'd2: begin
                q_hold <= div_quo;
                phase  <= 2'd3;
                state  <= ST_LAUNCH;
              end
              default: begin
                phase <= 2'd0;
                if (last_clk) begin
                  state <= ST_DONE;
                end else begin
                  ci    <= ci + 1'b1;
                  state <= ST_LAUNCH;
                end
              end
            endcase
          end
        end
        default: begin
          done     <= 1'b1;
          req_err  <= 1'b0;
          clk_sel  <= best_clk;
          step_sel <= best_step;
          cfg_word <= pack_cfg(best_clk, best_step);
          state    <= ST_IDLE;
        end
      endcase
    end
  end

  // The snapped step covers the ideal one and its lower neighbour does not.
  assert_snap_cover_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LAUNCH && phase == 2'd2) |->
      ((ACC_W'(step_size(step_q)) >= ideal_q) || (step_q == STEP_IW'(STEP_N - 1))));

  assert_snap_lowest_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LAUNCH && phase == 2'd2 && step_q != '0) |->
      (ACC_W'(step_size(step_q - 1'b1)) < ideal_q));

  assert_cfg_layout_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !req_err) |->
      (cfg_word[8] && cfg_word[7:0] == 8'h00 &&
       cfg_word[12:9] == clk_sel && cfg_word[15:13] == step_sel));

  assert_zero_reject_R5: assert property (@(posedge clk) disable iff (!rst_n)
    zero_req |=> (done && req_err && cfg_word == '0 && state == ST_IDLE));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(cfg_word) && $stable(req_err) && $stable(clk_sel)));

  assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    drop_start |=> $stable(slew_q));

endmodule

// File: tb/slew_fit_engine_tb.sv
module slew_fit_engine_tb_top;

  localparam longint unsigned NUM_K = 64'd65535000000;
  localparam int WAIT_MAX = 8000;
  localparam int DOG_MAX  = 190000;
  localparam int NVEC = 12;
  localparam logic [31:0] VEC [NVEC] = '{
    32'd1, 32'd16, 32'd100, 32'd1000, 32'd4096, 32'd12345,
    32'd65535, 32'd250000, 32'd1000000, 32'd40000000, 32'd7, 32'hFFFFFFFF
  };

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [31:0] slew_us;
  logic        done;
  logic        req_err;
  logic [3:0]  clk_sel;
  logic [2:0]  step_sel;
  logic [15:0] cfg_word;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  slew_fit_engine dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .slew_us (slew_us),
    .done    (done),
    .req_err (req_err),
    .clk_sel (clk_sel),
    .step_sel(step_sel),
    .cfg_word(cfg_word)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > DOG_MAX) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL R6 watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic longint unsigned rate_of(input int i);
    longint unsigned t [16] = '{240000, 200000, 150000, 128000, 64000, 32000,
                                16000, 8000, 4000, 2000, 1000, 512, 256, 128, 64, 16};
    return t[i];
  endfunction

  function automatic longint unsigned step_of(input int j);
    longint unsigned t [8] = '{4, 12, 64, 120, 256, 500, 1820, 2048};
    return t[j];
  endfunction

  // Independent statement of the search rules (R2, R3).
  task automatic model(input longint unsigned s, output int ci_e, output int si_e);
    longint unsigned best = 64'h7FFFFFFFFFFFFFFF;
    ci_e = 0;
    si_e = 0;
    for (int i = 0; i < 16; i++) begin
      longint unsigned ideal = (NUM_K / rate_of(i)) / s;
      int j = 7;
      longint unsigned ach;
      longint unsigned e;
      for (int k = 0; k < 8; k++) begin
        if (ideal <= step_of(k)) begin
          j = k;
          break;
        end
      end
      ach = (NUM_K / step_of(j)) / rate_of(i);
      e = (s > ach) ? s - ach : ach - s;
      if (e < best) begin
        best = e;
        ci_e = i;
        si_e = j;
      end
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_done(output bit got);
    got = 1'b0;
    for (int n = 0; n < WAIT_MAX; n++) begin
      if (done) begin
        got = 1'b1;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic pulse(input logic [31:0] s);
    @(negedge clk);
    start   = 1'b1;
    slew_us = s;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic check_result(input string req, input logic [31:0] s);
    int ce;
    int se;
    model(s, ce, se);
    chk({req, " clk_sel"}, 32'(clk_sel), ce);
    chk({req, " step_sel"}, 32'(step_sel), se);
    chk({req, " cfg_word"}, 32'(cfg_word), (se << 13) | (ce << 9) | 32'h100);
    chk({req, " req_err"}, 32'(req_err), 0);
  endtask

  initial begin
    bit got;
    logic [15:0] held;
    start   = 1'b0;
    slew_us = '0;
    rst_n   = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 done", 32'(done), 0);
    chk("R1 req_err", 32'(req_err), 0);
    chk("R1 clk_sel", 32'(clk_sel), 0);
    chk("R1 step_sel", 32'(step_sel), 0);
    chk("R1 cfg_word", 32'(cfg_word), 0);

    // R2 R3 R4: table of requests against the model
    for (int k = 0; k < NVEC; k++) begin
      pulse(VEC[k]);
      wait_done(got);
      chk("R6 done seen", 32'(got), 1);
      check_result("R3", VEC[k]);
    end

    // R2: slew 1 forces the step fallback to index 7 at clock index 0
    pulse(32'd1);
    wait_done(got);
    chk("R2 fallback cfg", 32'(cfg_word), 32'hE100);

    // R3: the largest slew time picks the slowest clock with the smallest step
    pulse(32'hFFFFFFFF);
    wait_done(got);
    chk("R3 far cfg", 32'(cfg_word), 32'h1F00);

    // R6: done lasts one cycle and the outputs hold afterwards
    held = cfg_word;
    @(negedge clk);
    chk("R6 done width", 32'(done), 0);
    repeat (30) @(negedge clk);
    chk("R6 hold cfg", 32'(cfg_word), 32'(held));
    chk("R6 hold done", 32'(done), 0);

    // R5: zero request flagged on the next cycle with cleared outputs
    pulse(32'd0);
    chk("R5 done", 32'(done), 1);
    chk("R5 req_err", 32'(req_err), 1);
    chk("R5 cfg_word", 32'(cfg_word), 0);
    chk("R5 clk_sel", 32'(clk_sel), 0);
    @(negedge clk);
    chk("R5 single pulse", 32'(done), 0);
    chk("R5 flag held", 32'(req_err), 1);
    pulse(32'd500);
    wait_done(got);
    check_result("R5 clear", 32'd500);

    // R7: a second start during the search does not alter its result
    pulse(32'd3000);
    repeat (100) @(negedge clk);
    start   = 1'b1;
    slew_us = 32'd20;
    @(negedge clk);
    start = 1'b0;
    wait_done(got);
    check_result("R7", 32'd3000);
    @(negedge clk);
    chk("R7 no extra done", 32'(done), 0);
    repeat (50) @(negedge clk);
    chk("R7 no second search", 32'(done), 0);

    // R8: start raised in the done cycle is accepted
    pulse(32'd800);
    wait_done(got);
    check_result("R8 first", 32'd800);
    start   = 1'b1;
    slew_us = 32'd90000;
    @(negedge clk);
    start = 1'b0;
    wait_done(got);
    chk("R8 second done", 32'(got), 1);
    check_result("R8 second", 32'd90000);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule